// File: doc/BRIEF.md
# Accumulator MAC compute cell

The block is a small programmable compute cell built around one 64-bit accumulator and a fused multiply-accumulate. It holds a 64-bit program counter, eight 64-bit scalar registers and two 16-bit pointers, one into a table of resident weights and one into a table of streamed operands. It executes 32-bit instructions from a local program store. Four local memories of 256 entries each hold the program, the 64-bit scalar data, the 32-bit weights and the 32-bit stream operands. Each memory writes on the clock edge and reads combinationally. The scalar data memory has a second read port that serves the debug view.

A host fills the memories through four write ports. Each port has its own enable, a 16-bit address and data, and the ports work only while the cell is idle. The host then pulses `go`. The cell runs one instruction per clock until it executes a stop instruction, and then it goes idle again. The host watches the run through the pc, accumulator, pointer, cycle and retired-instruction outputs. After the run it reads any scalar register or any data word through two combinational debug ports.

Top module: `mac_cell`

## Requirements
- R1: Reset (synchronous, active-low `rst_n`) leaves the cell idle with `halted`=1 and `busy`=0, and with `pc`, `acc`, `wptr`, `sptr`, `cycles`, `retired` and all scalar registers at zero.
- R2: A `go` pulse sampled while idle makes the cell busy on the next edge, with `pc`, `cycles` and `retired` cleared to zero. `acc`, the pointers, the registers and the memories keep their values.
- R3: The instruction fields are: opcode in bits [31:28], destination in [27:24], first source or branch-test register in [23:20], second source or store source in [19:16], and a 16-bit immediate in [15:0]. The opcodes are: 0 multiply-accumulate rs1*rs2 into acc (signed, low 64 bits); 2 clear acc; 3 copy acc to rd; 4 load the sign-extended immediate into rd; 5 load rd from data memory at the immediate; 6 store rs2 to data memory at the immediate.
- R4: Opcode 1 adds the product of the signed 32-bit weight at `wptr` and the signed 32-bit stream operand at `sptr` to acc. It then increments both pointers by one, with 16-bit wrap.
- R5: Opcode 9 branches when the test register is negative as a signed 64-bit value. The new pc is pc plus the sign-extended immediate, with no extra plus one. When the branch is not taken, pc advances by one.
- R6: Every memory index is the low eight bits of the address, pointer or pc presented to it. This covers host writes, fetch, loads, stores, weight and stream reads, and the debug data read. Each 4-bit register field selects the register given by its low three bits.
- R7: While busy, host memory writes and further `go` pulses are ignored. While idle with no `go`, pc, acc, the pointers and the counters hold.
- R8: Opcode 10 stops the run. It counts as retired, leaves pc on its own address and clears `busy`. `cycles` counts every busy cycle, so one instruction retires per busy cycle and `cycles` equals `retired` at the end of a run.
- R9: Opcodes 11 to 15 change no register, memory, pointer or acc. They advance pc by one and count as retired.
- R10: `dbg_reg_value` shows the register picked by `dbg_reg_sel`. `dbg_data_value` shows the data memory word at the low eight bits of `dbg_data_addr`. Both update combinationally.
- R11: Opcodes 7 and 8 load the 16-bit immediate into `wptr` and `sptr` respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start pulse, honoured while idle |
| prog_we | input | 1 | Program memory write enable |
| prog_addr | input | 16 | Program memory write address |
| prog_wdata | input | 32 | Program memory write data |
| dmem_we | input | 1 | Data memory write enable |
| dmem_addr | input | 16 | Data memory write address |
| dmem_wdata | input | 64 | Data memory write data |
| wgt_we | input | 1 | Weight memory write enable |
| wgt_addr | input | 16 | Weight memory write address |
| wgt_wdata | input | 32 | Weight memory write data |
| strm_we | input | 1 | Stream memory write enable |
| strm_addr | input | 16 | Stream memory write address |
| strm_wdata | input | 32 | Stream memory write data |
| dbg_reg_sel | input | 3 | Register chosen for debug view |
| dbg_data_addr | input | 16 | Data memory address for debug view |
| halted | output | 1 | Cell idle |
| busy | output | 1 | Cell running |
| pc | output | 64 | Program counter |
| acc | output | 64 | Accumulator |
| wptr | output | 16 | Weight pointer |
| sptr | output | 16 | Stream pointer |
| cycles | output | 64 | Busy cycles in the current or last run |
| retired | output | 64 | Instructions retired in the current or last run |
| dbg_reg_value | output | 64 | Value of the selected register |
| dbg_data_value | output | 64 | Data memory word at the debug address |

## Verification
A wrong pc or a wrong branch decision shows on `pc` one edge after the faulty instruction, and then on `retired` and `cycles` at the end of the run. A wrong product, a wrong sign extension or a wrong pointer index shows on `acc` or on `wptr`/`sptr` one edge later. A corrupted register or data word may stay hidden until a later instruction reads it, so the bench reads every register and every data word through the debug ports after each run. A host write that slips through while busy shows only as a changed memory word or a changed instruction stream, and the post-run sweep catches it.

// File: rtl/mac_cell_pkg.sv
`timescale 1ns/1ps
// Package: shared instruction encoding for the MAC compute cell.
// Assumes the fixed 32-bit instruction layout with a 16-bit immediate.
package mac_cell_pkg;

    typedef enum logic [3:0] {
        OP_MAC    = 4'd0,
        OP_KMAC   = 4'd1,
        OP_CLRACC = 4'd2,
        OP_MOVACC = 4'd3,
        OP_LI     = 4'd4,
        OP_LD     = 4'd5,
        OP_ST     = 4'd6,
        OP_SETWP  = 4'd7,
        OP_SETSP  = 4'd8,
        OP_BLZ    = 4'd9,
        OP_HALT   = 4'd10
    } op_e;

    typedef struct packed {
        logic [3:0]  op;
        logic [3:0]  rd;
        logic [3:0]  rs1;
        logic [3:0]  rs2;
        logic [15:0] imm;
    } instr_t;

    localparam int IMM_W = 16;

endpackage

// File: rtl/mc_mem.sv
`timescale 1ns/1ps
// Module: mc_mem
// Local memory model: one synchronous write port and N_RD combinational
// read ports. Contents are not reset; the host is expected to fill
// every entry it later reads.
module mc_mem #(
    parameter int WIDTH = 32,
    parameter int IDX_W = 8,
    parameter int N_RD  = 1
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [WIDTH-1:0]       wr_data,
    input  logic [N_RD*IDX_W-1:0]  rd_idx,
    output logic [N_RD*WIDTH-1:0]  rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [WIDTH-1:0] cells [DEPTH];

    // Store one word on the clock edge when enabled.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_idx] <= wr_data;
        end
    end

    // One combinational read path per port.
    generate
        for (genvar g = 0; g < N_RD; g++) begin : g_rd
            assign rd_data[g*WIDTH +: WIDTH] = cells[rd_idx[g*IDX_W +: IDX_W]];
        end
    endgenerate

endmodule

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
// Module: mc_regfile
// Scalar register file: one write port, three combinational read ports
// (two operands and the debug view). All registers clear on reset.
module mc_regfile #(
    parameter int XLEN  = 64,
    parameter int N_REG = 8,
    parameter int SEL_W = $clog2(N_REG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [SEL_W-1:0] rd_a_sel,
    output logic [XLEN-1:0]  rd_a,
    input  logic [SEL_W-1:0] rd_b_sel,
    output logic [XLEN-1:0]  rd_b,
    input  logic [SEL_W-1:0] rd_c_sel,
    output logic [XLEN-1:0]  rd_c
);
    logic [XLEN-1:0] regs [N_REG];

    // Clear on reset, otherwise write the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_REG; i++) begin
                regs[i] <= '0;
            end
        end else if (wr_en) begin
            regs[wr_sel] <= wr_data;
        end
    end

    assign rd_a = regs[rd_a_sel];
    assign rd_b = regs[rd_b_sel];
    assign rd_c = regs[rd_c_sel];

endmodule

// File: rtl/mc_exec.sv
`timescale 1ns/1ps
// Module: mc_exec
// Combinational decode and execute for one instruction. Produces the next
// pc, accumulator and pointers plus register and data-memory write requests.
// Assumes PTR_W equals the 16-bit immediate width and SEL_W is below 4.
module mc_exec
    import mac_cell_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int ELEM_W = 32,
    parameter int PTR_W  = 16,
    parameter int IDX_W  = 8,
    parameter int SEL_W  = 3
) (
    input  logic [31:0]      instr,
    input  logic [XLEN-1:0]  pc_cur,
    input  logic [XLEN-1:0]  acc_cur,
    input  logic [PTR_W-1:0] wptr_cur,
    input  logic [PTR_W-1:0] sptr_cur,
    input  logic [XLEN-1:0]  rs1_val,
    input  logic [XLEN-1:0]  rs2_val,
    input  logic [ELEM_W-1:0] wgt_val,
    input  logic [ELEM_W-1:0] strm_val,
    input  logic [XLEN-1:0]  ld_val,
    output logic [SEL_W-1:0] rs1_sel,
    output logic [SEL_W-1:0] rs2_sel,
    output logic             rf_we,
    output logic [SEL_W-1:0] rf_sel,
    output logic [XLEN-1:0]  rf_data,
    output logic             dm_we,
    output logic [IDX_W-1:0] dm_idx,
    output logic [XLEN-1:0]  dm_data,
    output logic [XLEN-1:0]  pc_nxt,
    output logic [XLEN-1:0]  acc_nxt,
    output logic [PTR_W-1:0] wptr_nxt,
    output logic [PTR_W-1:0] sptr_nxt,
    output logic             stop
);
    instr_t          ins;
    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] wgt_sx;
    logic [XLEN-1:0] strm_sx;
    logic            unused_fields;

    assign ins     = instr_t'(instr);
    assign imm_sx  = {{(XLEN-IMM_W){ins.imm[IMM_W-1]}}, ins.imm};
    assign wgt_sx  = {{(XLEN-ELEM_W){wgt_val[ELEM_W-1]}}, wgt_val};
    assign strm_sx = {{(XLEN-ELEM_W){strm_val[ELEM_W-1]}}, strm_val};

    // Register fields alias onto the low bits; the top bit is ignored.
    assign rs1_sel = ins.rs1[SEL_W-1:0];
    assign rs2_sel = ins.rs2[SEL_W-1:0];
    assign rf_sel  = ins.rd[SEL_W-1:0];
    assign dm_idx  = ins.imm[IDX_W-1:0];
    assign dm_data = rs2_val;
    assign unused_fields = ^{ins.rd[3:SEL_W], ins.rs1[3:SEL_W], ins.rs2[3:SEL_W]};

    // Decode the opcode and form every next-state value.
    always_comb begin
        pc_nxt   = pc_cur + XLEN'(1);
        acc_nxt  = acc_cur;
        wptr_nxt = wptr_cur;
        sptr_nxt = sptr_cur;
        rf_we    = 1'b0;
        rf_data  = imm_sx;
        dm_we    = 1'b0;
        stop     = 1'b0;
        case (ins.op)
            OP_MAC:    acc_nxt = acc_cur + rs1_val * rs2_val;
            OP_KMAC: begin
                acc_nxt  = acc_cur + wgt_sx * strm_sx;
                wptr_nxt = wptr_cur + PTR_W'(1);
                sptr_nxt = sptr_cur + PTR_W'(1);
            end
            OP_CLRACC: acc_nxt = '0;
            OP_MOVACC: begin
                rf_we   = 1'b1;
                rf_data = acc_cur;
            end
            OP_LI:     rf_we = 1'b1;
            OP_LD: begin
                rf_we   = 1'b1;
                rf_data = ld_val;
            end
            OP_ST:     dm_we = 1'b1;
            OP_SETWP:  wptr_nxt = ins.imm[PTR_W-1:0];
            OP_SETSP:  sptr_nxt = ins.imm[PTR_W-1:0];
            OP_BLZ: begin
                if (rs1_val[XLEN-1]) begin
                    pc_nxt = pc_cur + imm_sx;
                end
            end
            OP_HALT: begin
                pc_nxt = pc_cur;
                stop   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mac_cell.sv
`timescale 1ns/1ps
// Module: mac_cell
// Top of the accumulator MAC compute cell. Holds the run state, pc,
// accumulator, pointers and counters; muxes host loading against the
// running core; executes one instruction per busy cycle.
// Assumes the host drives memory writes only while halted (others ignored).
module mac_cell
    import mac_cell_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int ELEM_W  = 32,
    parameter int LADDR_W = 16,
    parameter int IDX_W   = 8,
    parameter int N_REG   = 8,
    parameter int INSTR_W = 32,
    localparam int SEL_W  = $clog2(N_REG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic               prog_we,
    input  logic [LADDR_W-1:0] prog_addr,
    input  logic [INSTR_W-1:0] prog_wdata,
    input  logic               dmem_we,
    input  logic [LADDR_W-1:0] dmem_addr,
    input  logic [XLEN-1:0]    dmem_wdata,
    input  logic               wgt_we,
    input  logic [LADDR_W-1:0] wgt_addr,
    input  logic [ELEM_W-1:0]  wgt_wdata,
    input  logic               strm_we,
    input  logic [LADDR_W-1:0] strm_addr,
    input  logic [ELEM_W-1:0]  strm_wdata,
    input  logic [SEL_W-1:0]   dbg_reg_sel,
    input  logic [LADDR_W-1:0] dbg_data_addr,
    output logic               halted,
    output logic               busy,
    output logic [XLEN-1:0]    pc,
    output logic [XLEN-1:0]    acc,
    output logic [LADDR_W-1:0] wptr,
    output logic [LADDR_W-1:0] sptr,
    output logic [XLEN-1:0]    cycles,
    output logic [XLEN-1:0]    retired,
    output logic [XLEN-1:0]    dbg_reg_value,
    output logic [XLEN-1:0]    dbg_data_value
);
    logic               running;
    logic [XLEN-1:0]    pc_q, acc_q, cyc_q, ret_q;
    logic [LADDR_W-1:0] wptr_q, sptr_q;

    logic [INSTR_W-1:0] instr_word;
    logic [ELEM_W-1:0]  wgt_val, strm_val;
    logic [XLEN-1:0]    ld_val;
    logic [2*XLEN-1:0]  dm_rd;
    logic [XLEN-1:0]    rs1_val, rs2_val;

    logic [SEL_W-1:0]   rs1_sel, rs2_sel, rf_sel;
    logic               rf_we, dm_we, stop;
    logic [XLEN-1:0]    rf_data, dm_data;
    logic [IDX_W-1:0]   dm_idx;
    logic [XLEN-1:0]    pc_nxt, acc_nxt;
    logic [LADDR_W-1:0] wptr_nxt, sptr_nxt;

    logic               dm_wr_en;
    logic [IDX_W-1:0]   dm_wr_idx;
    logic [XLEN-1:0]    dm_wr_data;
    logic               unused_addr_hi;

    assign unused_addr_hi = ^{prog_addr[LADDR_W-1:IDX_W], dmem_addr[LADDR_W-1:IDX_W],
                              wgt_addr[LADDR_W-1:IDX_W], strm_addr[LADDR_W-1:IDX_W],
                              dbg_data_addr[LADDR_W-1:IDX_W]};

    // Program store: host write while idle, fetch at the low pc bits.
    mc_mem #(.WIDTH(INSTR_W), .IDX_W(IDX_W), .N_RD(1)) u_prog (
        .clk     (clk),
        .wr_en   (prog_we && !running),
        .wr_idx  (prog_addr[IDX_W-1:0]),
        .wr_data (prog_wdata),
        .rd_idx  (pc_q[IDX_W-1:0]),
        .rd_data (instr_word)
    );

    // Resident weights, read at the weight pointer.
    mc_mem #(.WIDTH(ELEM_W), .IDX_W(IDX_W), .N_RD(1)) u_wgt (
        .clk     (clk),
        .wr_en   (wgt_we && !running),
        .wr_idx  (wgt_addr[IDX_W-1:0]),
        .wr_data (wgt_wdata),
        .rd_idx  (wptr_q[IDX_W-1:0]),
        .rd_data (wgt_val)
    );

    // Streamed operands, read at the stream pointer.
    mc_mem #(.WIDTH(ELEM_W), .IDX_W(IDX_W), .N_RD(1)) u_strm (
        .clk     (clk),
        .wr_en   (strm_we && !running),
        .wr_idx  (strm_addr[IDX_W-1:0]),
        .wr_data (strm_wdata),
        .rd_idx  (sptr_q[IDX_W-1:0]),
        .rd_data (strm_val)
    );

    // Data memory write port: the core owns it while running, the host otherwise.
    always_comb begin
        if (running) begin
            dm_wr_en   = dm_we;
            dm_wr_idx  = dm_idx;
            dm_wr_data = dm_data;
        end else begin
            dm_wr_en   = dmem_we;
            dm_wr_idx  = dmem_addr[IDX_W-1:0];
            dm_wr_data = dmem_wdata;
        end
    end

    // Scalar data memory with a load port and a debug port.
    mc_mem #(.WIDTH(XLEN), .IDX_W(IDX_W), .N_RD(2)) u_dmem (
        .clk     (clk),
        .wr_en   (dm_wr_en),
        .wr_idx  (dm_wr_idx),
        .wr_data (dm_wr_data),
        .rd_idx  ({dbg_data_addr[IDX_W-1:0], dm_idx}),
        .rd_data (dm_rd)
    );
    assign ld_val         = dm_rd[XLEN-1:0];
    assign dbg_data_value = dm_rd[2*XLEN-1:XLEN];

    // Scalar registers.
    mc_regfile #(.XLEN(XLEN), .N_REG(N_REG), .SEL_W(SEL_W)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rf_we && running),
        .wr_sel   (rf_sel),
        .wr_data  (rf_data),
        .rd_a_sel (rs1_sel),
        .rd_a     (rs1_val),
        .rd_b_sel (rs2_sel),
        .rd_b     (rs2_val),
        .rd_c_sel (dbg_reg_sel),
        .rd_c     (dbg_reg_value)
    );

    // Decode and execute the fetched instruction.
    mc_exec #(.XLEN(XLEN), .ELEM_W(ELEM_W), .PTR_W(LADDR_W), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_exec (
        .instr    (instr_word),
        .pc_cur   (pc_q),
        .acc_cur  (acc_q),
        .wptr_cur (wptr_q),
        .sptr_cur (sptr_q),
        .rs1_val  (rs1_val),
        .rs2_val  (rs2_val),
        .wgt_val  (wgt_val),
        .strm_val (strm_val),
        .ld_val   (ld_val),
        .rs1_sel  (rs1_sel),
        .rs2_sel  (rs2_sel),
        .rf_we    (rf_we),
        .rf_sel   (rf_sel),
        .rf_data  (rf_data),
        .dm_we    (dm_we),
        .dm_idx   (dm_idx),
        .dm_data  (dm_data),
        .pc_nxt   (pc_nxt),
        .acc_nxt  (acc_nxt),
        .wptr_nxt (wptr_nxt),
        .sptr_nxt (sptr_nxt),
        .stop     (stop)
    );

    // Run state: enter on go while idle, leave on the stop instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
        end else if (!running) begin
            running <= go;
        end else if (stop) begin
            running <= 1'b0;
        end
    end

    // Architectural state: pc restarts on go, everything advances while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            acc_q  <= '0;
            wptr_q <= '0;
            sptr_q <= '0;
        end else if (!running) begin
            if (go) begin
                pc_q <= '0;
            end
        end else begin
            pc_q   <= pc_nxt;
            acc_q  <= acc_nxt;
            wptr_q <= wptr_nxt;
            sptr_q <= sptr_nxt;
        end
    end

    // Run counters: cleared on go, one step per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
            ret_q <= '0;
        end else if (!running) begin
            if (go) begin
                cyc_q <= '0;
                ret_q <= '0;
            end
        end else begin
            cyc_q <= cyc_q + XLEN'(1);
            ret_q <= ret_q + XLEN'(1);
        end
    end

    assign halted  = !running;
    assign busy    = running;
    assign pc      = pc_q;
    assign acc     = acc_q;
    assign wptr    = wptr_q;
    assign sptr    = sptr_q;
    assign cycles  = cyc_q;
    assign retired = ret_q;

    // Assertion helpers.
    instr_t          cur_ins;
    logic [XLEN-1:0] br_off;
    assign cur_ins = instr_t'(instr_word);
    assign br_off  = {{(XLEN-IMM_W){cur_ins.imm[IMM_W-1]}}, cur_ins.imm};

    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |=> (halted && !busy && pc == '0 && acc == '0 && wptr == '0 && sptr == '0
                    && cycles == '0 && retired == '0)); // R1

    AST_GO_ENTERS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && go) |=> (busy && pc == '0 && cycles == '0 && retired == '0)); // R2

    AST_KMAC_STEPS_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_ins.op == OP_KMAC) |=>
            (wptr == $past(wptr) + LADDR_W'(1) && sptr == $past(sptr) + LADDR_W'(1))); // R4

    AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_ins.op == OP_BLZ && rs1_val[XLEN-1]) |=>
            (pc == $past(pc) + $past(br_off))); // R5

    AST_BRANCH_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_ins.op == OP_BLZ && !rs1_val[XLEN-1]) |=>
            (pc == $past(pc) + XLEN'(1))); // R5

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !go) |=> ($stable(pc) && $stable(acc) && $stable(wptr) && $stable(sptr)
                             && $stable(cycles) && $stable(retired))); // R7

    AST_HALT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_ins.op == OP_HALT) |=>
            (halted && pc == $past(pc) && retired == $past(retired) + XLEN'(1))); // R8

    AST_CYCLES_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (cycles == $past(cycles) + XLEN'(1) && cycles == retired)); // R8

endmodule

// File: tb/test_mac_cell.sv
`timescale 1ns/1ps
// Bench for mac_cell: directed programs plus seeded random programs,
// checked against an instruction-level reference model in the bench.
module test_mac_cell;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic        prog_we = 1'b0;
    logic [15:0] prog_addr = '0;
    logic [31:0] prog_wdata = '0;
    logic        dmem_we = 1'b0;
    logic [15:0] dmem_addr = '0;
    logic [63:0] dmem_wdata = '0;
    logic        wgt_we = 1'b0;
    logic [15:0] wgt_addr = '0;
    logic [31:0] wgt_wdata = '0;
    logic        strm_we = 1'b0;
    logic [15:0] strm_addr = '0;
    logic [31:0] strm_wdata = '0;
    logic [2:0]  dbg_reg_sel = '0;
    logic [15:0] dbg_data_addr = '0;
    logic        halted, busy;
    logic [63:0] pc, acc, cycles, retired, dbg_reg_value, dbg_data_value;
    logic [15:0] wptr, sptr;

    mac_cell i_mac_cell (
        .clk(clk), .rst_n(rst_n), .go(go),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_wdata(prog_wdata),
        .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .wgt_we(wgt_we), .wgt_addr(wgt_addr), .wgt_wdata(wgt_wdata),
        .strm_we(strm_we), .strm_addr(strm_addr), .strm_wdata(strm_wdata),
        .dbg_reg_sel(dbg_reg_sel), .dbg_data_addr(dbg_data_addr),
        .halted(halted), .busy(busy), .pc(pc), .acc(acc), .wptr(wptr), .sptr(sptr),
        .cycles(cycles), .retired(retired),
        .dbg_reg_value(dbg_reg_value), .dbg_data_value(dbg_data_value)
    );

    always #10 clk = ~clk;  // 50 MHz

    int n_vec = 0;
    int n_bad = 0;

    // Reference state.
    logic [31:0] m_prog [256];
    logic [63:0] m_dmem [256];
    logic [31:0] m_wgt  [256];
    logic [31:0] m_strm [256];
    logic [63:0] m_reg  [8];
    logic [63:0] m_acc = '0;
    logic [63:0] m_pc = '0;
    logic [63:0] m_ret = '0;
    logic [15:0] m_wp = '0;
    logic [15:0] m_sp = '0;

    task automatic check(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input int op, input int rd, input int rs1,
                                        input int rs2, input logic [15:0] imm);
        return {op[3:0], rd[3:0], rs1[3:0], rs2[3:0], imm};
    endfunction

    // Host write tasks: called at a negedge, return at the next negedge.
    task automatic put_prog(input logic [15:0] a, input logic [31:0] d);
        prog_we = 1'b1; prog_addr = a; prog_wdata = d;
        @(negedge clk);
        prog_we = 1'b0;
        m_prog[a[7:0]] = d;
    endtask

    task automatic put_dmem(input logic [15:0] a, input logic [63:0] d);
        dmem_we = 1'b1; dmem_addr = a; dmem_wdata = d;
        @(negedge clk);
        dmem_we = 1'b0;
        m_dmem[a[7:0]] = d;
    endtask

    task automatic put_wgt(input logic [15:0] a, input logic [31:0] d);
        wgt_we = 1'b1; wgt_addr = a; wgt_wdata = d;
        @(negedge clk);
        wgt_we = 1'b0;
        m_wgt[a[7:0]] = d;
    endtask

    task automatic put_strm(input logic [15:0] a, input logic [31:0] d);
        strm_we = 1'b1; strm_addr = a; strm_wdata = d;
        @(negedge clk);
        strm_we = 1'b0;
        m_strm[a[7:0]] = d;
    endtask

    // Reference interpreter, run from pc 0 until the stop instruction.
    task automatic model_run();
        logic [31:0] w;
        logic [3:0]  op;
        logic [2:0]  rd, ra, rb;
        logic [63:0] sx, pw, ps;
        m_pc  = '0;
        m_ret = '0;
        for (int n = 0; n < 4000; n++) begin
            w  = m_prog[m_pc[7:0]];
            op = w[31:28];
            rd = w[26:24];
            ra = w[22:20];
            rb = w[18:16];
            sx = {{48{w[15]}}, w[15:0]};
            m_ret = m_ret + 64'd1;
            if (op == 4'd10) break;
            case (op)
                4'd0: m_acc = m_acc + m_reg[ra] * m_reg[rb];
                4'd1: begin
                    pw = {{32{m_wgt[m_wp[7:0]][31]}}, m_wgt[m_wp[7:0]]};
                    ps = {{32{m_strm[m_sp[7:0]][31]}}, m_strm[m_sp[7:0]]};
                    m_acc = m_acc + pw * ps;
                    m_wp = m_wp + 16'd1;
                    m_sp = m_sp + 16'd1;
                end
                4'd2: m_acc = '0;
                4'd3: m_reg[rd] = m_acc;
                4'd4: m_reg[rd] = sx;
                4'd5: m_reg[rd] = m_dmem[w[7:0]];
                4'd6: m_dmem[w[7:0]] = m_reg[rb];
                4'd7: m_wp = w[15:0];
                4'd8: m_sp = w[15:0];
                default: ;
            endcase
            if (op == 4'd9 && m_reg[ra][63]) m_pc = m_pc + sx;
            else m_pc = m_pc + 64'd1;
        end
    endtask

    // Pulse go from a negedge, check run entry, wait for the cell to stop.
    task automatic run_dut();
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        check("R2", "busy after go", {63'd0, busy}, 64'd1);
        check("R2", "retired cleared", retired, 64'd0);
        check("R2", "pc restart", pc, 64'd0);
        for (int n = 0; n < 5000 && !halted; n++) @(negedge clk);
    endtask

    // Compare every visible output and the whole debug view with the model.
    task automatic compare_all(input string req);
        check(req, "pc", pc, m_pc);
        check(req, "acc", acc, m_acc);
        check(req, "retired", retired, m_ret);
        check("R8", "cycles equal retired", cycles, m_ret);
        check(req, "wptr", {48'd0, wptr}, {48'd0, m_wp});
        check(req, "sptr", {48'd0, sptr}, {48'd0, m_sp});
        check("R8", "halted after run", {63'd0, halted}, 64'd1);
        for (int r = 0; r < 8; r++) begin
            dbg_reg_sel = r[2:0];
            #1;
            check("R10", "register view", dbg_reg_value, m_reg[r]);
        end
        for (int a = 0; a < 256; a++) begin
            dbg_data_addr = {8'($urandom), a[7:0]};
            #1;
            check("R6", "data view", dbg_data_value, m_dmem[a]);
        end
        @(negedge clk);
    endtask

    initial begin
        int          seed_v;
        logic [63:0] dot;
        logic [63:0] v;
        seed_v = $urandom(32'h5EED_0042);
        for (int r = 0; r < 8; r++) m_reg[r] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "halted", {63'd0, halted}, 64'd1);
        check("R1", "busy", {63'd0, busy}, 64'd0);
        check("R1", "pc", pc, 64'd0);
        check("R1", "acc", acc, 64'd0);
        check("R1", "cycles", cycles, 64'd0);
        check("R1", "retired", retired, 64'd0);
        check("R1", "wptr", {48'd0, wptr}, 64'd0);
        check("R1", "sptr", {48'd0, sptr}, 64'd0);
        for (int r = 0; r < 8; r++) begin
            dbg_reg_sel = r[2:0];
            #1;
            check("R1", "register cleared", dbg_reg_value, 64'd0);
        end
        @(negedge clk);

        // Fill all memories; the program store is filled with stop words.
        for (int a = 0; a < 256; a++) begin
            put_prog(16'(a), enc(10, 0, 0, 0, 16'h0));
            put_dmem(16'(a), {$urandom, $urandom});
            put_wgt(16'(a), $urandom);
            put_strm(16'(a), $urandom);
        end

        // R4, R11: dot product of eight weight/stream pairs.
        put_prog(16'd0, enc(7, 0, 0, 0, 16'd3));
        put_prog(16'd1, enc(8, 0, 0, 0, 16'd10));
        put_prog(16'd2, enc(2, 0, 0, 0, 16'd0));
        for (int k = 0; k < 8; k++) put_prog(16'(3 + k), enc(1, 0, 0, 0, 16'd0));
        put_prog(16'd11, enc(10, 0, 0, 0, 16'd0));
        dot = '0;
        for (int k = 0; k < 8; k++)
            dot = dot + {{32{m_wgt[3+k][31]}}, m_wgt[3+k]} * {{32{m_strm[10+k][31]}}, m_strm[10+k]};
        model_run();
        run_dut();
        check("R4", "dot product acc", acc, dot);
        check("R11", "wptr after dot", {48'd0, wptr}, 64'd11);
        check("R11", "sptr after dot", {48'd0, sptr}, 64'd18);
        check("R8", "pc parks on stop", pc, 64'd11);
        check("R8", "retired includes stop", retired, 64'd12);
        compare_all("R4");

        // R5: taken forward, taken backward and not-taken branches.
        put_prog(16'd0, enc(4, 1, 0, 0, 16'hFFFF));
        put_prog(16'd1, enc(4, 2, 0, 0, 16'hFFFE));
        put_prog(16'd2, enc(4, 3, 0, 0, 16'd5));
        put_prog(16'd3, enc(9, 0, 1, 0, 16'd4));
        put_prog(16'd4, enc(9, 0, 3, 0, 16'd9));
        put_prog(16'd5, enc(10, 0, 0, 0, 16'd0));
        put_prog(16'd6, enc(4, 6, 0, 0, 16'h0066));
        put_prog(16'd7, enc(9, 0, 2, 0, 16'hFFFD));
        model_run();
        run_dut();
        check("R5", "branch end pc", pc, 64'd5);
        check("R5", "branch path length", retired, 64'd7);
        dbg_reg_sel = 3'd6;
        #1;
        check("R5", "skipped instruction had no effect", dbg_reg_value, 64'd0);
        compare_all("R5");

        // R3: multiply-accumulate, clear and copy of acc.
        put_prog(16'd0, enc(4, 1, 0, 0, 16'hFFF9));
        put_prog(16'd1, enc(4, 2, 0, 0, 16'd1000));
        put_prog(16'd2, enc(2, 0, 0, 0, 16'd0));
        put_prog(16'd3, enc(0, 0, 1, 2, 16'd0));
        put_prog(16'd4, enc(0, 0, 1, 1, 16'd0));
        put_prog(16'd5, enc(3, 6, 0, 0, 16'd0));
        put_prog(16'd6, enc(10, 0, 0, 0, 16'd0));
        model_run();
        run_dut();
        dbg_reg_sel = 3'd6;
        #1;
        check("R3", "mac result copied", dbg_reg_value, 64'hFFFF_FFFF_FFFF_E4D9);
        compare_all("R3");

        // R6: high address bits ignored, register fields alias, pointer wrap.
        put_dmem(16'hC305, 64'h0123_4567_89AB_CDEF);
        dbg_data_addr = 16'h7705;
        #1;
        check("R6", "debug read aliases", dbg_data_value, 64'h0123_4567_89AB_CDEF);
        @(negedge clk);
        put_prog(16'h4A00, enc(4, 11, 0, 0, 16'h8001));
        put_prog(16'h4A01, enc(5, 2, 0, 0, 16'h7705));
        put_prog(16'h4A02, enc(6, 0, 0, 10, 16'h1240));
        put_prog(16'h4A03, enc(7, 0, 0, 0, 16'h03FF));
        put_prog(16'h4A04, enc(8, 0, 0, 0, 16'hFFFF));
        put_prog(16'h4A05, enc(2, 0, 0, 0, 16'd0));
        put_prog(16'h4A06, enc(1, 0, 0, 0, 16'd0));
        put_prog(16'h4A07, enc(10, 0, 0, 0, 16'd0));
        model_run();
        run_dut();
        dbg_reg_sel = 3'd3;
        #1;
        check("R6", "rd field 11 writes r3", dbg_reg_value, 64'hFFFF_FFFF_FFFF_8001);
        dbg_data_addr = 16'h0040;
        #1;
        check("R6", "store at aliased index", dbg_data_value, 64'h0123_4567_89AB_CDEF);
        check("R11", "wptr wraps past index", {48'd0, wptr}, 64'h0400);
        check("R4", "sptr 16-bit wrap", {48'd0, sptr}, 64'h0000);
        compare_all("R6");

        // R9: unused opcodes act as no-ops.
        put_prog(16'd0, enc(4, 4, 0, 0, 16'd3));
        for (int k = 0; k < 5; k++) put_prog(16'(1 + k), enc(11 + k, k, 1, 2, 16'(k * 37)));
        put_prog(16'd6, enc(4, 5, 0, 0, 16'd4));
        put_prog(16'd7, enc(10, 0, 0, 0, 16'd0));
        v = acc;
        model_run();
        run_dut();
        check("R9", "no-op path length", retired, 64'd8);
        check("R9", "acc untouched", acc, v);
        compare_all("R9");

        // R7: host writes and go are ignored while busy.
        for (int k = 0; k < 20; k++) put_prog(16'(k), enc(4, 7, 0, 0, 16'(k)));
        put_prog(16'd20, enc(10, 0, 0, 0, 16'd0));
        model_run();
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        dmem_we = 1'b1; dmem_addr = 16'd9; dmem_wdata = ~m_dmem[9];
        prog_we = 1'b1; prog_addr = 16'd20; prog_wdata = enc(4, 7, 0, 0, 16'h0099);
        wgt_we = 1'b1; wgt_addr = m_wp; wgt_wdata = ~m_wgt[m_wp[7:0]];
        @(negedge clk);
        dmem_we = 1'b0; prog_we = 1'b0; wgt_we = 1'b0;
        repeat (3) @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        for (int n = 0; n < 200 && !halted; n++) @(negedge clk);
        check("R7", "go while busy did not restart", retired, 64'd21);
        check("R7", "program write blocked", pc, 64'd20);
        dbg_data_addr = 16'd9;
        #1;
        check("R7", "data write blocked", dbg_data_value, m_dmem[9]);
        compare_all("R7");
        // Weight write blocked: one multiply-accumulate reads the protected word.
        put_prog(16'd0, enc(2, 0, 0, 0, 16'd0));
        put_prog(16'd1, enc(1, 0, 0, 0, 16'd0));
        put_prog(16'd2, enc(10, 0, 0, 0, 16'd0));
        put_prog(16'd3, enc(10, 0, 0, 0, 16'd0));
        model_run();
        run_dut();
        compare_all("R7");
        repeat (4) @(negedge clk);
        check("R7", "idle holds pc", pc, m_pc);

        // Random programs: forward branches only, stop words after the end.
        for (int t = 0; t < 40; t++) begin
            int len;
            len = $urandom_range(8, 40);
            for (int k = 0; k < len; k++) begin
                int op;
                logic [15:0] imm;
                op  = $urandom_range(0, 15);
                imm = 16'($urandom);
                if (op == 9) imm = 16'($urandom_range(1, 3));
                if (op == 10 && $urandom_range(0, 3) != 0) op = 1;
                put_prog(16'(k), enc(op, $urandom_range(0, 15), $urandom_range(0, 15),
                                     $urandom_range(0, 15), imm));
            end
            for (int k = 0; k < 4; k++) put_prog(16'(len + k), enc(10, 0, 0, 0, 16'd0));
            model_run();
            run_dut();
            compare_all("R3");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL R8 watchdog actual=%0d expected=<150000 cycles", 150000);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule